// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable single-port synchronous SRAM with flow-through reads. It also contains a small burst address generator that steps only the two lowest address bits. The address, write data, chip enables, address strobes, advance input and write controls are all captured on the rising clock edge. Read data leaves the array without an output register. The word for an address captured at one edge is therefore on the data-out port during the clock period that follows that edge. This gives 2-1-1-1 burst timing. A host can also skip bursts and load a new address on every cycle.

Two strobes can load an address. The processor-side strobe is ignored when the first chip enable is inactive, and it never writes on its loading edge. The controller-side strobe loads whenever it is asserted. Each load also records whether all three chip enables were active.

A write at an edge stores the write data at the address registered before that edge. A global write stores every byte. Otherwise the byte-write enable together with per-byte lanes selects the bytes to store. Output enable and sleep gate the output without waiting for a clock edge. While sleep is high, no clocked input has any effect.

Top module: `burst_sram_ft`

## Requirements
- R1: While reset is held and just after it is released, `dout_vld_o` is 0 and `dout_o` is all zeros. Whenever `dout_vld_o` is 0, `dout_o` is zero.
- R2: An edge with `ctl_strobe_ni`=0 loads `addr_i` as the current address. An edge with `cpu_strobe_ni`=0 loads `addr_i` only when `ce1_ni`=0; otherwise that strobe is ignored.
- R3: The part is selected only if the last load saw `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. A load that sees any enable inactive deselects the part. A deselected part drives `dout_vld_o`=0 and ignores writes.
- R4: Reads are flow-through. After the edge that loads address A, `dout_o` shows word A within that same clock period. A new address may be loaded on every edge.
- R5: With `order_sel_i`=0 (linear), burst step k shows address bits [1:0] = (start[1:0]+k) mod 4. The upper bits stay unchanged.
- R6: With `order_sel_i`=1 (interleaved), burst step k shows address bits [1:0] = start[1:0] XOR k. The upper bits stay unchanged.
- R7: The burst counter steps once per edge with `adv_ni`=0 and no load. With `adv_ni`=1 and no load, the current address holds.
- R8: A byte write is `byte_we_ni`=0 with `all_we_ni`=1. It stores only the bytes whose lane bit `lane_we_ni[i]`=0, where byte i is data bits [8i+7:8i]. With `byte_we_ni`=1, the lane bits have no effect.
- R9: `all_we_ni`=0 stores the whole word, whatever `byte_we_ni` and `lane_we_ni` hold.
- R10: A write at an edge stores `din_i` at the address that was current before that edge. An edge at which the processor-side strobe loads performs no write.
- R11: `dout_vld_o` is 1 only while `oe_ni`=0, the part is selected, `sleep_i`=0 and no write is requested. `oe_ni` and `sleep_i` take effect without a clock edge.
- R12: While `sleep_i`=1, strobes, advance and writes have no effect. Array contents and the current address are kept through sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low reset of burst and select state |
| addr_i | input | ADDR_W | External word address |
| din_i | input | BYTES*BYTE_W | Write data |
| ce1_ni | input | 1 | Chip enable 1, active low; also gates the processor-side strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| cpu_strobe_ni | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_we_ni | input | BYTES | Per-byte write lanes, active low |
| byte_we_ni | input | 1 | Byte-write enable, active low |
| all_we_ni | input | 1 | Global write, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous |
| dout_o | output | BYTES*BYTE_W | Read data, zero when not valid |
| dout_vld_o | output | 1 | Read data valid |

## Verification
The bench walks bursts from non-aligned start addresses in both orders. It checks the wrap of the low two bits. A design that used the wrong order, or that carried into bit 2, would read a neighbouring block. It starts a processor-strobe load while the write controls are held low. A design that honoured the write on that edge would overwrite the previous address. It masks the byte lanes one at a time and then overrides them with a global write. This catches lane swaps and a global write that still obeys the lanes. It also toggles output enable and sleep between clock edges, and it tries loads and writes both while deselected and while asleep. Each of these must leave the address and the array untouched.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low two address bits for burst step 'step' from start 'base'.
    function automatic logic [1:0] burst_low(logic [1:0] base, logic [1:0] step,
                                             burst_order_e ord);
        return (ord == ORD_INTERLEAVE) ? (base ^ step) : (base + step);
    endfunction

endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr
    import sram_pkg::*;
(
    input  logic [1:0] base_i,
    input  logic [1:0] step_i,
    input  logic       order_i,
    output logic [1:0] low_o
);
    always_comb begin
        low_o = burst_low(base_i, step_i, burst_order_e'(order_i));
    end
endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
    parameter int BYTES = 2
) (
    input  logic             all_we_ni,
    input  logic             byte_we_ni,
    input  logic [BYTES-1:0] lane_we_ni,
    output logic [BYTES-1:0] lane_en_o,
    output logic             any_o
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane_en_o[g] = !all_we_ni || (!byte_we_ni && !lane_we_ni[g]);
    end
    assign any_o = |lane_en_o;
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [BYTES-1:0]        we_i,
    input  logic [BYTES*BYTE_W-1:0] wdata_i,
    output logic [BYTES*BYTE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk_i) begin
            if (we_i[g]) mem[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
        end
        assign rdata_o[g*BYTE_W +: BYTE_W] = mem[addr_i];
    end
endmodule

// File: rtl/burst_sram_ft.sv
module burst_sram_ft #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [BYTES*BYTE_W-1:0] din_i,
    input  logic                    ce1_ni,
    input  logic                    ce2_i,
    input  logic                    ce3_ni,
    input  logic                    cpu_strobe_ni,
    input  logic                    ctl_strobe_ni,
    input  logic                    adv_ni,
    input  logic                    order_sel_i,
    input  logic [BYTES-1:0]        lane_we_ni,
    input  logic                    byte_we_ni,
    input  logic                    all_we_ni,
    input  logic                    oe_ni,
    input  logic                    sleep_i,
    output logic [BYTES*BYTE_W-1:0] dout_o,
    output logic                    dout_vld_o
);
    localparam int DATA_W = BYTES * BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        step;
        logic              sel;
    } state_t;

    state_t state_d, state_q;

    logic              cpu_load, ctl_load, load, all_en;
    logic [1:0]        low;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTES-1:0]  lane_en, lane_we;
    logic              wr_any, wr_req;
    logic [DATA_W-1:0] rdata;

    assign cpu_load = !cpu_strobe_ni && !ce1_ni && !sleep_i;
    assign ctl_load = !ctl_strobe_ni && !sleep_i;
    assign load     = cpu_load || ctl_load;
    assign all_en   = !ce1_ni && ce2_i && !ce3_ni;

    sram_burst_ctr i_ctr (
        .base_i  (state_q.base[1:0]),
        .step_i  (state_q.step),
        .order_i (order_sel_i),
        .low_o   (low)
    );

    assign cur_addr = {state_q.base[ADDR_W-1:2], low};

    sram_wr_decode #(.BYTES(BYTES)) i_dec (
        .all_we_ni  (all_we_ni),
        .byte_we_ni (byte_we_ni),
        .lane_we_ni (lane_we_ni),
        .lane_en_o  (lane_en),
        .any_o      (wr_any)
    );

    // A processor-strobe load edge is a read; writes need a selected part.
    assign wr_req  = wr_any && state_q.sel && !cpu_load && !sleep_i;
    assign lane_we = lane_en & {BYTES{wr_req}};

    sram_byte_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) i_arr (
        .clk_i   (clk_i),
        .addr_i  (cur_addr),
        .we_i    (lane_we),
        .wdata_i (din_i),
        .rdata_o (rdata)
    );

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.base = addr_i;
            state_d.step = 2'd0;
            state_d.sel  = all_en;
        end else if (!adv_ni && !sleep_i) begin
            state_d.step = state_q.step + 2'd1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign dout_vld_o = !oe_ni && state_q.sel && !wr_req && !sleep_i;
    assign dout_o     = dout_vld_o ? rdata : '0;
endmodule

// File: rtl/sram_ft_checker.sv
module sram_ft_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ce1_ni,
    input logic              ce2_i,
    input logic              cpu_strobe_ni,
    input logic              ctl_strobe_ni,
    input logic              adv_ni,
    input logic              order_sel_i,
    input logic              oe_ni,
    input logic              sleep_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_vld_o,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              wr_req
);
    a_r1_zero_when_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dout_vld_o |-> dout_o == '0);

    a_r2_ctl_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && !ctl_strobe_ni) |=> cur_addr == $past(addr_i));

    a_r2_cpu_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && ce1_ni && !cpu_strobe_ni && ctl_strobe_ni && adv_ni) |=> $stable(cur_addr));

    a_r3_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && !ctl_strobe_ni && !ce2_i) |=> !dout_vld_o);

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_i || (adv_ni && ctl_strobe_ni && (cpu_strobe_ni || ce1_ni))) |=> $stable(cur_addr));

    // R5 and R6: a step changes only the low two bits
    a_r5_step_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && !adv_ni && ctl_strobe_ni && (cpu_strobe_ni || ce1_ni))
        |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])) &&
            ((cur_addr[1:0] != $past(cur_addr[1:0])) || (order_sel_i != $past(order_sel_i))));

    a_r10_cpu_load_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cpu_strobe_ni && !ce1_ni) |-> !wr_req);

    a_r11_valid_gating: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dout_vld_o |-> (!oe_ni && !sleep_i && !wr_req));
endmodule

bind burst_sram_ft sram_ft_checker #(.ADDR_W(ADDR_W), .DATA_W(BYTES*BYTE_W)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_i        (addr_i),
    .ce1_ni        (ce1_ni),
    .ce2_i         (ce2_i),
    .cpu_strobe_ni (cpu_strobe_ni),
    .ctl_strobe_ni (ctl_strobe_ni),
    .adv_ni        (adv_ni),
    .order_sel_i   (order_sel_i),
    .oe_ni         (oe_ni),
    .sleep_i       (sleep_i),
    .dout_o        (dout_o),
    .dout_vld_o    (dout_vld_o),
    .cur_addr      (cur_addr),
    .wr_req        (wr_req)
);

// File: tb/test_burst_sram_ft.sv
module test_burst_sram_ft;
    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int DW = NB * BW;
    localparam int NV = 8;
    // {address, data} pairs written with global write, read back via processor strobe
    localparam logic [AW+DW-1:0] VEC [NV] = '{
        {6'h10, 16'hC0DE}, {6'h3F, 16'h0001}, {6'h21, 16'h8000}, {6'h2A, 16'hFFFF},
        {6'h33, 16'h55AA}, {6'h18, 16'h0000}, {6'h2C, 16'h1234}, {6'h0F, 16'hFEDC}};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1, order = 1'b1;
    logic [NB-1:0] lanes_n = '1;
    logic byte_we_n = 1'b1, all_we_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] dout;
    logic vld;

    burst_sram_ft #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) i_burst_sram_ft (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .din_i(din),
        .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
        .cpu_strobe_ni(cpu_n), .ctl_strobe_ni(ctl_n), .adv_ni(adv_n),
        .order_sel_i(order), .lane_we_ni(lanes_n), .byte_we_ni(byte_we_n),
        .all_we_ni(all_we_n), .oe_ni(oe_n), .sleep_i(sleep),
        .dout_o(dout), .dout_vld_o(vld));

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [1 << AW];

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tick; @(posedge clk); #1; endtask

    task automatic load_ctl(logic [AW-1:0] a);
        ctl_n = 1'b0; addr = a; tick; ctl_n = 1'b1;
    endtask

    task automatic load_cpu(logic [AW-1:0] a);
        cpu_n = 1'b0; addr = a; tick; cpu_n = 1'b1;
    endtask

    task automatic gwrite(logic [AW-1:0] a, logic [DW-1:0] d);
        all_we_n = 1'b0; din = d; tick; all_we_n = 1'b1; model[a] = d;
    endtask

    task automatic burst_chk(logic [AW-1:0] base, logic ord, string req);
        order = ord;
        load_ctl(base);
        adv_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [1:0] lo;
            lo = ord ? (base[1:0] ^ 2'(k)) : (base[1:0] + 2'(k));
            #1 chk(req, dout, model[{base[AW-1:2], lo}]);
            tick;
        end
        adv_n = 1'b1;
        order = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 chk("R1 vld in reset", {15'd0, vld}, 16'd0);
        chk("R1 dout in reset", dout, 16'd0);
        rst_n = 1'b1;
        tick;
        #1 chk("R1 vld after reset", {15'd0, vld}, 16'd0);

        // prefill block 0..7
        for (int a = 0; a < 8; a++) begin
            load_ctl(6'(a));
            gwrite(6'(a), 16'(a * 16'h0F31 + 16'h1234));
        end

        // R9 R4: vector table, global write then readback
        for (int i = 0; i < NV; i++) begin
            load_ctl(VEC[i][AW+DW-1:DW]);
            gwrite(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
        end
        for (int i = 0; i < NV; i++) begin
            load_cpu(VEC[i][AW+DW-1:DW]);
            #1 chk("R4 R9 table readback", dout, VEC[i][DW-1:0]);
            chk("R11 table valid", {15'd0, vld}, 16'd1);
        end

        // R4: new address every edge
        ctl_n = 1'b0;
        for (int a = 0; a < 4; a++) begin
            addr = 6'(a); tick;
            #1 chk("R4 back-to-back", dout, model[a]);
        end
        ctl_n = 1'b1;

        // R5 R6: both orders from non-aligned starts
        burst_chk(6'h05, 1'b0, "R5 linear 5");
        burst_chk(6'h05, 1'b1, "R6 interleave 5");
        burst_chk(6'h02, 1'b0, "R5 linear 2");
        burst_chk(6'h02, 1'b1, "R6 interleave 2");

        // R7: hold without advance
        load_ctl(6'h06);
        adv_n = 1'b0; tick; adv_n = 1'b1;
        tick; tick;
        #1 chk("R7 hold", dout, model[7]);

        // R8: byte lanes
        load_ctl(6'h03);
        byte_we_n = 1'b0; lanes_n = 2'b10; din = 16'hABCD; tick;
        byte_we_n = 1'b1; lanes_n = 2'b11;
        model[3][7:0] = 8'hCD;
        #1 chk("R8 lane0 only", dout, model[3]);
        lanes_n = 2'b00; din = 16'hFFFF; tick; lanes_n = 2'b11;
        #1 chk("R8 lanes without enable", dout, model[3]);
        byte_we_n = 1'b0; lanes_n = 2'b01; din = 16'h7700; tick;
        byte_we_n = 1'b1; lanes_n = 2'b11;
        model[3][15:8] = 8'h77;
        #1 chk("R8 lane1 only", dout, model[3]);

        // R9: global write overrides lanes
        byte_we_n = 1'b1; lanes_n = 2'b11;
        gwrite(6'h03, 16'h1234);
        #1 chk("R9 global overrides", dout, 16'h1234);

        // R10: processor-strobe load edge performs no write
        cpu_n = 1'b0; addr = 6'h04; all_we_n = 1'b0; din = 16'hDEAD;
        #1 chk("R10 no write on cpu load", {15'd0, vld}, 16'd1);
        tick; cpu_n = 1'b1; all_we_n = 1'b1;
        #1 chk("R10 new address intact", dout, model[4]);
        load_ctl(6'h03);
        #1 chk("R10 old address intact", dout, model[3]);

        // R11: asynchronous output enable and write gating
        oe_n = 1'b1;
        #1 chk("R11 oe off vld", {15'd0, vld}, 16'd0);
        chk("R1 zero when invalid", dout, 16'd0);
        oe_n = 1'b0;
        #1 chk("R11 oe on vld", {15'd0, vld}, 16'd1);
        all_we_n = 1'b0;
        #1 chk("R11 write blocks vld", {15'd0, vld}, 16'd0);
        all_we_n = 1'b1;
        #1 chk("R11 write released", {15'd0, vld}, 16'd1);

        // R3: deselect by any enable
        ce2 = 1'b0; load_ctl(6'h05); ce2 = 1'b1;
        #1 chk("R3 ce2 deselect", {15'd0, vld}, 16'd0);
        gwrite(6'h05, 16'hBEEF); model[5] = 16'(5 * 16'h0F31 + 16'h1234);
        ce3_n = 1'b1; load_ctl(6'h05); ce3_n = 1'b0;
        #1 chk("R3 ce3 deselect", {15'd0, vld}, 16'd0);
        load_ctl(6'h05);
        #1 chk("R3 write ignored", dout, model[5]);

        // R2: processor strobe gated by ce1, then accepted
        load_ctl(6'h06);
        ce1_n = 1'b1; cpu_n = 1'b0; addr = 6'h07; tick; cpu_n = 1'b1; ce1_n = 1'b0;
        #1 chk("R2 cpu strobe ignored", dout, model[6]);
        load_cpu(6'h07);
        #1 chk("R2 cpu strobe loads", dout, model[7]);

        // R12: sleep
        load_ctl(6'h02);
        sleep = 1'b1;
        #1 chk("R12 sleep vld", {15'd0, vld}, 16'd0);
        ctl_n = 1'b0; addr = 6'h01; all_we_n = 1'b0; adv_n = 1'b0; din = 16'h0BAD;
        tick; tick;
        ctl_n = 1'b1; all_we_n = 1'b1; adv_n = 1'b1;
        sleep = 1'b0;
        #1 chk("R12 retained after sleep", dout, model[2]);
        load_ctl(6'h01);
        #1 chk("R12 no write in sleep", dout, model[1]);

        summary;
    end
endmodule